// File: doc/BRIEF.md
# Scanline Fetch Timing Sequencer

This block produces the horizontal and vertical timing of a tile-based video renderer and decides, cycle by cycle, which kind of external memory fetch the renderer should make. It counts master clock cycles within a line (1364 per line) and lines within a frame. Each line is divided into 170 slots of 8 cycles followed by 4 idle cycles. Every slot is labelled as a background fetch (name, attribute, pattern low, pattern high), a sprite pattern fetch, a discarded name fetch, or nothing.

The frame starts with a vertical-blank stretch with no fetches. A pre-render line follows; it fetches like a normal line. Then come the visible lines and one idle line. A vertical-blank flag and a one-cycle interrupt pulse mark the end of the idle line. When rendering is enabled during the pre-render line, that line drops its trailing 4 idle cycles on every second such frame. Address generation, scrolling and pixel output live in neighbouring blocks that decode `fetch_kind`.

Top module: `scan_fetch_seq`

## Requirements
- R1: `hcount` counts 0 to 1363 and then returns to 0, so a normal line lasts 1364 cycles.
- R2: Lines are numbered from 0, with 0 the first vertical-blank line. A frame is VBLANK_LINES + VISIBLE_LINES + 2 lines long, which is 262 lines by default. `vcount` returns to 0 after the last line.
- R3: Take slot number s = hcount/8 + 1. In slots 1–128 and 161–168, `fetch_kind` follows the repeating order 1 (name), 2 (attribute), 3 (pattern low), 4 (pattern high), starting from slot 1.
- R4: Slots 129–160 repeat the group 5, 5, 6, 7, where 5 is a discarded name fetch, 6 is sprite pattern low and 7 is sprite pattern high. Slots 169 and 170 are both 1 (name). Cycles 1360–1363 are 0 (none).
- R5: `rd_strobe` is high exactly in the first cycle of each slot whose `fetch_kind` is not 0. A rendered line therefore has 170 strobes.
- R6: `line_phase` is 0 on the vertical-blank lines (0 .. VBLANK_LINES-1), 1 on the pre-render line, 2 on the visible lines and 3 on the final idle line.
- R7: While `render_en` is low, and on every line of phase 0 or 3, `fetch_kind` is 0 and `rd_strobe` is low.
- R8: `vblank` rises in the cycle in which `vcount` wraps to 0, and `irq` is high for that one cycle only. `vblank` is low from the first cycle of the pre-render line onward.
- R9: The pre-render line ends after cycle 1359 (1360 cycles long) when the parity bit is 1 and `render_en` is high at hcount 1359. Otherwise it is 1364 cycles long.
- R10: The parity bit toggles at hcount 1359 of the pre-render line if `render_en` is high in that cycle. Otherwise it holds. With rendering always on after reset, pre-render lines alternate between long and short, starting with long.
- R11: Synchronous reset sets hcount 0, vcount 0, parity 0, and `vblank` and `irq` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | master clock |
| rst | input | 1 | synchronous reset, active high |
| render_en | input | 1 | background or sprite rendering enabled |
| hcount | output | 11 | cycle within line |
| vcount | output | VW (9 by default) | line within frame |
| line_phase | output | 2 | 0 vblank, 1 pre-render, 2 visible, 3 post-render |
| fetch_kind | output | 3 | slot fetch type, encoding in R3/R4 |
| rd_strobe | output | 1 | one-cycle read request per fetch slot |
| vblank | output | 1 | vertical-blank flag |
| irq | output | 1 | one-cycle pulse when vblank sets |

## Verification
The bench shortens the frame to 3 blank and 4 visible lines and compares every output against a behavioural model on every clock. The tests cover several input patterns. Rendering held on for several frames shows the long/short alternation of the pre-render line. A frame with rendering off must have no fetches and must not advance the parity. Toggling `render_en` every 700 cycles lands the enable on either side of the cycle-1359 decision, which separates the parity and length rules. A reset in mid-frame confirms that the counters restart at vertical blank.

// File: rtl/scan_fetch_seq.sv
module scan_fetch_seq #(
  parameter int VBLANK_LINES  = 20,
  parameter int VISIBLE_LINES = 240,
  localparam int TOTAL_LINES  = VBLANK_LINES + VISIBLE_LINES + 2,
  localparam int VW           = $clog2(TOTAL_LINES)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          render_en,
  output logic [10:0]   hcount,
  output logic [VW-1:0] vcount,
  output logic [1:0]    line_phase,
  output logic [2:0]    fetch_kind,
  output logic          rd_strobe,
  output logic          vblank,
  output logic          irq
);
  localparam int LINE_CYC   = 1364;
  localparam int SHORT_LAST = 1359;
  localparam int PRE_LINE   = VBLANK_LINES;
  localparam int POST_LINE  = VBLANK_LINES + VISIBLE_LINES + 1;

  logic odd;
  logic [7:0] slot;
  logic rendering, parity_tick, line_end;

  assign line_phase = (vcount < VW'(PRE_LINE))   ? 2'd0 :
                      (vcount == VW'(PRE_LINE))  ? 2'd1 :
                      (vcount == VW'(POST_LINE)) ? 2'd3 : 2'd2;
  assign rendering   = render_en && (line_phase == 2'd1 || line_phase == 2'd2);
  assign slot        = hcount[10:3];
  assign parity_tick = line_phase == 2'd1 && render_en && hcount == 11'(SHORT_LAST);
  assign line_end    = hcount == 11'(LINE_CYC - 1) || (parity_tick && odd);

  always_comb begin
    fetch_kind = 3'd0;
    if (rendering && slot < 8'd170) begin
      if (slot >= 8'd168)
        fetch_kind = 3'd1;
      else if (slot >= 8'd128 && slot < 8'd160)
        fetch_kind = slot[1] ? (slot[0] ? 3'd7 : 3'd6) : 3'd5;
      else
        fetch_kind = {1'b0, slot[1:0]} + 3'd1;
    end
  end

  assign rd_strobe = fetch_kind != 3'd0 && hcount[2:0] == 3'd0;

  always_ff @(posedge clk) begin
    if (rst) begin
      hcount <= '0;
      vcount <= '0;
      odd    <= 1'b0;
      vblank <= 1'b0;
      irq    <= 1'b0;
    end else begin
      irq <= 1'b0;
      if (parity_tick) odd <= ~odd;
      if (line_end) begin
        hcount <= '0;
        if (vcount == VW'(POST_LINE)) begin
          vcount <= '0;
          vblank <= 1'b1;
          irq    <= 1'b1;
        end else begin
          vcount <= vcount + 1'b1;
          if (vcount == VW'(PRE_LINE - 1)) vblank <= 1'b0;
        end
      end else begin
        hcount <= hcount + 1'b1;
      end
    end
  end

  a_r1_hcount_wrap: assert property (@(posedge clk) disable iff (rst)
    hcount == 11'(LINE_CYC - 1) |=> hcount == 11'd0);
  a_r1_hcount_range: assert property (@(posedge clk) disable iff (rst)
    hcount < 11'(LINE_CYC));
  a_r7_quiet_blank: assert property (@(posedge clk) disable iff (rst)
    (line_phase == 2'd0 || line_phase == 2'd3 || !render_en) |-> (fetch_kind == 3'd0 && !rd_strobe));
  a_r8_irq_single: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);
  a_r8_irq_with_flag: assert property (@(posedge clk) disable iff (rst)
    $rose(vblank) |-> irq);
  a_r8_clear_pre: assert property (@(posedge clk) disable iff (rst)
    line_phase == 2'd1 |-> !vblank);
  a_r9_short_wrap: assert property (@(posedge clk) disable iff (rst)
    (line_phase == 2'd1 && hcount == 11'(SHORT_LAST) && render_en && odd) |=> hcount == 11'd0);
endmodule

// File: tb/tb_scan_fetch_seq.sv
module tb_scan_fetch_seq;
  localparam int VBL = 3, VIS = 4;
  localparam int PRE = VBL, POST = VBL + VIS + 1;
  localparam int VW = $clog2(VBL + VIS + 2);

  logic clk = 0, rst = 1, render_en = 0;
  logic [10:0] hcount;
  logic [VW-1:0] vcount;
  logic [1:0] line_phase;
  logic [2:0] fetch_kind;
  logic rd_strobe, vblank, irq;

  int checks = 0, errors = 0, cyc = 0;
  int mh = 0, mv = 0, mpar = 0;
  bit mvb = 0, mirq = 0;
  bit done = 0;

  always #4 clk = ~clk;

  scan_fetch_seq #(.VBLANK_LINES(VBL), .VISIBLE_LINES(VIS)) dut (
    .clk(clk), .rst(rst), .render_en(render_en), .hcount(hcount), .vcount(vcount),
    .line_phase(line_phase), .fetch_kind(fetch_kind), .rd_strobe(rd_strobe),
    .vblank(vblank), .irq(irq));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      if (errors < 20) $display("FAIL %s at cycle %0d: actual %0d expected %0d", req, cyc, act, exp);
    end
  endtask

  function automatic int exp_phase(int v);
    if (v < PRE) return 0;
    if (v == PRE) return 1;
    if (v == POST) return 3;
    return 2;
  endfunction

  function automatic int exp_kind(int h, int v, bit en);
    int s, r;
    if (!en || exp_phase(v) == 0 || exp_phase(v) == 3 || h >= 1360) return 0;
    s = h / 8 + 1;
    if (s <= 128 || (s >= 161 && s <= 168)) return (s - 1) % 4 + 1;
    if (s <= 160) begin
      r = (s - 129) % 4;
      return r < 2 ? 5 : (r == 2 ? 6 : 7);
    end
    return 1;
  endfunction

  always @(posedge clk) begin
    bit tick, endl;
    cyc++;
    if (rst) begin
      mh = 0; mv = 0; mpar = 0; mvb = 0; mirq = 0;
    end else begin
      tick = (mv == PRE) && render_en && (mh == 1359);
      endl = (mh == 1363) || (tick && mpar == 1);
      if (tick) mpar = 1 - mpar;
      mirq = 0;
      if (endl) begin
        mh = 0;
        if (mv == POST) begin mv = 0; mvb = 1; mirq = 1; end
        else begin mv++; if (mv == PRE) mvb = 0; end
      end else mh++;
    end
  end

  always @(negedge clk) begin
    int k;
    if (!rst && !done) begin
      k = exp_kind(mh, mv, render_en);
      chk("R1 hcount", hcount, mh);
      chk("R2 vcount", vcount, mv);
      chk("R6 line_phase", line_phase, exp_phase(mv));
      chk("R3/R4/R7 fetch_kind", fetch_kind, k);
      chk("R5 rd_strobe", rd_strobe, (k != 0 && mh % 8 == 0) ? 1 : 0);
      chk("R8 vblank", vblank, mvb);
      chk("R8 irq", irq, mirq);
    end
  end

  task automatic frames(int n);
    repeat (n * (VBL + VIS + 2) * 1364) @(negedge clk);
  endtask

  initial begin
    int len, strobes;
    repeat (5) @(negedge clk);
    chk("R11 reset hcount", hcount, 0);
    chk("R11 reset vcount", vcount, 0);
    chk("R11 reset vblank", vblank, 0);
    chk("R11 reset irq", irq, 0);
    rst = 0;
    render_en = 1;
    // R9/R10: first pre-render line long, second short
    for (int f = 0; f < 2; f++) begin
      while (!(vcount == VW'(PRE) && hcount == 0)) @(negedge clk);
      len = 0; strobes = 0;
      do begin
        len++;
        if (rd_strobe) strobes++;
        @(negedge clk);
      end while (hcount != 0);
      chk(f == 0 ? "R10 first pre-render long" : "R9 second pre-render short", len, f == 0 ? 1364 : 1360);
      chk("R5 strobes per rendered line", strobes, 170);
    end
    frames(1);
    render_en = 0;   // R7 and R10: no fetches, parity held
    frames(1);
    render_en = 1;
    frames(2);
    for (int i = 0; i < 20; i++) begin
      render_en = ~render_en;
      repeat (700) @(negedge clk);
    end
    render_en = 1;
    repeat (5000) @(negedge clk);
    rst = 1;
    @(negedge clk);
    rst = 0;
    frames(1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    done = 1;
    errors++;
    checks++;
    $display("FAIL watchdog expired: actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule